// File: doc/BRIEF.md
# Multimode Preset Timer Cell

This block is a single hardware timer that behaves like one of five classic control-logic timers: a pulse, an extended (latched) pulse, an on-delay, a latching on-delay, or an off-delay. A 16-bit preset word supplies the duration as a two-bit time-base code and three BCD digits. Once the timer is running, the remaining time drops by one unit on each tick of the selected time base. A built-in tick generator divides the system clock into 10 ms, 100 ms, 1 s and 10 s enable pulses.

Three control inputs drive the cell. A start input is edge-triggered for starting. A clear input is level-sensitive and dominant. A release input retriggers a running timer on its rising edge, but only while start is high. The cell drives a status output and reports the remaining time in two forms: a binary count and the BCD word together with its time-base bits. Both forms are updated in the same clock cycle as each countdown step.

Top module: `tmr_cell`

## Requirements
- R1: `presetWord[13:12]` selects the time base (00 = 10 ms, 01 = 100 ms, 10 = 1 s, 11 = 10 s). `presetWord[11:0]` holds three BCD digits, hundreds in [11:8] and units in [3:0]. Bits [15:14] have no effect. While running, the remaining time falls by one unit per tick of the latched base.
- R2: The 10 ms tick fires once every CLK_HZ/100 clock cycles, counting from the first edge after reset. Each slower base fires on every tenth tick of the next faster base. Every tick lasts one cycle.
- R3: `modeSel` 0 is pulse mode. A start rising edge sets the output and loads the time. The output falls when the time elapses or when start is low.
- R4: `modeSel` 1 is extended pulse mode. A start rising edge sets the output for the full time even if start falls. A new start rising edge while running reloads the time.
- R5: `modeSel` 2 is on-delay mode. A start rising edge loads the time with the output low. The output rises when the time elapses with start still high. Start low clears the output and stops timing.
- R6: `modeSel` 3 is latching on-delay mode. The output rises when the time elapses, whatever the level of start. A start rising edge while running reloads the time. Only clear lowers the output.
- R7: `modeSel` 4 is off-delay mode. A start rising edge sets the output and halts timing. A start falling edge while the output is high loads the time. The output falls when the time elapses.
- R8: While `clearIn` is high, the output is low and the remaining time (binary, BCD and time-base bits) is zero, whatever the start input does.
- R9: In modes 0 to 3, a release rising edge reloads a running timer only when start is high. A release edge with start low, or with the timer stopped, changes nothing.
- R10: `remainBin` is the binary value of the remaining BCD count. `remainBcd` is {2'b00, time base, BCD count}. Both change in the same cycle as a load or a countdown step.
- R11: `modeSel` codes 5 to 7 hold the output low and stop timing.
- R12: Only a rising edge on start begins timing. A start level that is already high when clear falls does not set the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Timer start / trigger level |
| clearIn | input | 1 | Dominant clear of output and remaining time |
| releaseIn | input | 1 | Retrigger on rising edge while start is high |
| modeSel | input | 3 | Timer behaviour select (0 to 4, 5 to 7 idle) |
| presetWord | input | 16 | Time base [13:12] and BCD duration [11:0] |
| outQ | output | 1 | Timer status output |
| remainBin | output | 10 | Remaining time, binary |
| remainBcd | output | 16 | Remaining time, BCD with time-base bits |

## Verification
The assertions assume that `modeSel` changes only while `clearIn` is high. They also assume that every preset digit is a legal BCD value (0 to 9). A mode change during timing, or a digit above nine, falls outside the block's defined behaviour. The random stimulus picks a new mode and preset only inside a clear window and builds each preset from digits drawn in the range 0 to 9. Between those windows it toggles start, clear and release freely.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NDIG      = 3;
  localparam int DIG_W     = 4;
  localparam int BCD_W     = NDIG * DIG_W;
  localparam int TB_W      = 2;
  localparam int NUM_BASES = 1 << TB_W;
  localparam int CNT_W     = 10;
  localparam int MODE_W    = 3;
  localparam int PRESET_W  = 16;

  typedef enum logic [MODE_W-1:0] {
    MODE_PULSE = 3'd0,
    MODE_EXT   = 3'd1,
    MODE_ONDLY = 3'd2,
    MODE_LATCH = 3'd3,
    MODE_OFFD  = 3'd4
  } modeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } strobeT;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BASE_HZ   = 100,
  parameter int NUM_BASES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic [NUM_BASES-1:0] ticks
);
  localparam int BASE_DIV = (CLK_HZ / BASE_HZ < 1) ? 1 : CLK_HZ / BASE_HZ;
  localparam int DIV_W    = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             baseTick;
  logic [3:0]       decCnt [1:NUM_BASES-1];

  assign baseTick = (divCnt == DIV_W'(BASE_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (baseTick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  // Each slower base is the carry-out of a decade stage
  always_comb begin
    logic carry;
    carry    = baseTick;
    ticks[0] = baseTick;
    for (int g = 1; g < NUM_BASES; g++) begin
      carry    = carry & (decCnt[g] == 4'd9);
      ticks[g] = carry;
    end
  end

  for (genvar g = 1; g < NUM_BASES; g++) begin : gDecade
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             decCnt[g] <= '0;
      else if (ticks[g-1])   decCnt[g] <= (decCnt[g] == 4'd9) ? 4'd0 : decCnt[g] + 4'd1;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import timer_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeT                    strobe,
  input  logic [TB_W+BCD_W-1:0]     presetLow,
  output logic [CNT_W-1:0]          remainBin,
  output logic [BCD_W-1:0]          remainDigits,
  output logic [TB_W-1:0]           tbSel,
  output logic                      countLast
);
  function automatic logic [BCD_W-1:0] bcdDecrement(input logic [BCD_W-1:0] v);
    logic [BCD_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (borrow) begin
        if (r[i*DIG_W +: DIG_W] == '0) r[i*DIG_W +: DIG_W] = DIG_W'(9);
        else begin
          r[i*DIG_W +: DIG_W] = r[i*DIG_W +: DIG_W] - 1'b1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] bcdToBin(input logic [BCD_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = NDIG - 1; i >= 0; i--)
      acc = CNT_W'(acc * 10) + CNT_W'(v[i*DIG_W +: DIG_W]);
    return acc;
  endfunction

  logic [BCD_W-1:0] loadDigits;
  assign loadDigits = presetLow[BCD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remainBin    <= '0;
      remainDigits <= '0;
      tbSel        <= '0;
    end else if (strobe.clear) begin
      remainBin    <= '0;
      remainDigits <= '0;
      tbSel        <= '0;
    end else if (strobe.load) begin
      remainBin    <= bcdToBin(loadDigits);
      remainDigits <= loadDigits;
      tbSel        <= presetLow[TB_W+BCD_W-1:BCD_W];
    end else if (strobe.dec && remainBin != '0) begin
      remainBin    <= remainBin - 1'b1;
      remainDigits <= bcdDecrement(remainDigits);
    end
  end

  assign countLast = (remainBin <= CNT_W'(1));
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              clearIn,
  input  logic              releaseIn,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              tickHit,
  input  logic              countLast,
  output strobeT            strobe,
  output logic              outQ
);
  logic startPrev, releasePrev, running;
  logic startRise, startFall, releaseRise, restart, step;
  logic qNext, runNext;

  always_comb begin
    startRise   = startIn & ~startPrev;
    startFall   = ~startIn & startPrev;
    releaseRise = releaseIn & ~releasePrev;
    restart     = startRise | (releaseRise & startIn & running);
    step        = running & tickHit;
    qNext       = outQ;
    runNext     = running;
    strobe      = '0;
    if (clearIn) begin
      strobe.clear = 1'b1;
      qNext        = 1'b0;
      runNext      = 1'b0;
    end else begin
      case (modeT'(modeSel))
        MODE_PULSE: begin
          if (restart) begin
            strobe.load = 1'b1; runNext = 1'b1; qNext = 1'b1;
          end else if (!startIn) begin
            runNext = 1'b0; qNext = 1'b0;
          end else if (step) begin
            strobe.dec = 1'b1;
            if (countLast) begin runNext = 1'b0; qNext = 1'b0; end
          end
        end
        MODE_EXT: begin
          if (restart) begin
            strobe.load = 1'b1; runNext = 1'b1; qNext = 1'b1;
          end else if (step) begin
            strobe.dec = 1'b1;
            if (countLast) begin runNext = 1'b0; qNext = 1'b0; end
          end
        end
        MODE_ONDLY: begin
          if (restart) begin
            strobe.load = 1'b1; runNext = 1'b1; qNext = 1'b0;
          end else if (!startIn) begin
            runNext = 1'b0; qNext = 1'b0;
          end else if (step) begin
            strobe.dec = 1'b1;
            if (countLast) begin runNext = 1'b0; qNext = 1'b1; end
          end
        end
        MODE_LATCH: begin
          if (restart) begin
            strobe.load = 1'b1; runNext = 1'b1;
          end else if (step) begin
            strobe.dec = 1'b1;
            if (countLast) begin runNext = 1'b0; qNext = 1'b1; end
          end
        end
        MODE_OFFD: begin
          if (startRise) begin
            runNext = 1'b0; qNext = 1'b1;
          end else if (startFall && outQ) begin
            strobe.load = 1'b1; runNext = 1'b1;
          end else if (step) begin
            strobe.dec = 1'b1;
            if (countLast) begin runNext = 1'b0; qNext = 1'b0; end
          end
        end
        default: begin
          runNext = 1'b0; qNext = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrev   <= 1'b0;
      releasePrev <= 1'b0;
      running     <= 1'b0;
      outQ        <= 1'b0;
    end else begin
      startPrev   <= startIn;
      releasePrev <= releaseIn;
      running     <= runNext;
      outQ        <= qNext;
    end
  end
endmodule

// File: rtl/tmr_cell.sv
module tmr_cell
  import timer_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic                clearIn,
  input  logic                releaseIn,
  input  logic [MODE_W-1:0]   modeSel,
  input  logic [PRESET_W-1:0] presetWord,
  output logic                outQ,
  output logic [CNT_W-1:0]    remainBin,
  output logic [PRESET_W-1:0] remainBcd
);
  logic [NUM_BASES-1:0] ticks;
  logic [TB_W-1:0]      tbSel;
  logic [BCD_W-1:0]     remainDigits;
  logic                 countLast;
  logic                 tickHit;
  strobeT               strobe;
  logic                 unusedPresetHi;

  assign unusedPresetHi = ^presetWord[PRESET_W-1:TB_W+BCD_W];

  tmr_tick_gen #(.CLK_HZ(CLK_HZ), .BASE_HZ(100), .NUM_BASES(NUM_BASES)) uTick (
    .clk(clk), .rstN(rstN), .ticks(ticks)
  );

  assign tickHit = ticks[tbSel];

  tmr_control uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .clearIn(clearIn),
    .releaseIn(releaseIn), .modeSel(modeSel), .tickHit(tickHit),
    .countLast(countLast), .strobe(strobe), .outQ(outQ)
  );

  tmr_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .presetLow(presetWord[TB_W+BCD_W-1:0]),
    .remainBin(remainBin), .remainDigits(remainDigits),
    .tbSel(tbSel), .countLast(countLast)
  );

  assign remainBcd = {{(PRESET_W-TB_W-BCD_W){1'b0}}, tbSel, remainDigits};
endmodule

// File: rtl/tmr_cell_chk.sv
module tmr_cell_chk
  import timer_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                startIn,
  input logic                clearIn,
  input logic [MODE_W-1:0]   modeSel,
  input logic                outQ,
  input logic [CNT_W-1:0]    remainBin,
  input logic [PRESET_W-1:0] remainBcd
);
  logic [CNT_W-1:0] bcdValue;
  assign bcdValue = CNT_W'(remainBcd[11:8]) * CNT_W'(100)
                  + CNT_W'(remainBcd[7:4]) * CNT_W'(10)
                  + CNT_W'(remainBcd[3:0]);

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (!outQ && remainBin == '0 && remainBcd == '0));

  a_r3_pulse_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_PULSE && !startIn) |=> !outQ);

  a_r5_ondelay_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_ONDLY && !startIn) |=> !outQ);

  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_LATCH && outQ && !clearIn) |=> outQ);

  a_r7_off_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_OFFD && startIn && !$past(startIn) && !clearIn) |=> outQ);

  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel > MODE_OFFD) |=> !outQ);

  a_r10_bin_matches_bcd: assert property (@(posedge clk) disable iff (!rstN)
    remainBin == bcdValue);

  a_r1_range: assert property (@(posedge clk) disable iff (!rstN)
    remainBin <= CNT_W'(999));
endmodule

bind tmr_cell tmr_cell_chk uChk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .clearIn(clearIn),
  .modeSel(modeSel), .outQ(outQ), .remainBin(remainBin), .remainBcd(remainBcd)
);

// File: tb/tb_tmr_cell.sv
module tb_tmr_cell;
  localparam int CLK_HZ_TB = 400;
  localparam int DIV       = CLK_HZ_TB / 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0, clearIn = 1'b0, releaseIn = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic [15:0] presetWord = 16'h0005;
  logic        outQ;
  logic [9:0]  remainBin;
  logic [15:0] remainBcd;

  int tests = 0, fails = 0, wd = 0;

  always #10 clk = ~clk;

  tmr_cell #(.CLK_HZ(CLK_HZ_TB)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .clearIn(clearIn),
    .releaseIn(releaseIn), .modeSel(modeSel), .presetWord(presetWord),
    .outQ(outQ), .remainBin(remainBin), .remainBcd(remainBcd)
  );

  function automatic int periodFor(input int tb);
    case (tb)
      0: return DIV;
      1: return DIV * 10;
      2: return DIV * 100;
      default: return DIV * 1000;
    endcase
  endfunction

  function automatic int bcd2bin(input logic [11:0] v);
    return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [11:0] bin2bcd(input int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  // Reference model from the requirements
  bit mq, mRun, mPrevS, mPrevR;
  int mCnt, mTb, cyc;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mq = 0; mRun = 0; mCnt = 0; mTb = 0; mPrevS = 0; mPrevR = 0; cyc = 0;
    end else begin
      bit rise, fall, rel, tk, restart;
      rise = startIn && !mPrevS;
      fall = !startIn && mPrevS;
      rel  = releaseIn && !mPrevR;
      tk   = mRun && (((cyc + 1) % periodFor(mTb)) == 0);
      restart = rise || (rel && startIn && mRun);
      if (clearIn) begin
        mq = 0; mRun = 0; mCnt = 0; mTb = 0;
      end else begin
        case (modeSel)
          3'd0, 3'd1, 3'd2, 3'd3: begin
            if (restart) begin
              mCnt = bcd2bin(presetWord[11:0]); mTb = int'(presetWord[13:12]); mRun = 1;
              if (modeSel == 3'd0 || modeSel == 3'd1) mq = 1;
              if (modeSel == 3'd2) mq = 0;
            end else if (!startIn && (modeSel == 3'd0 || modeSel == 3'd2)) begin
              mRun = 0; mq = 0;
            end else if (tk) begin
              mCnt = (mCnt > 0) ? mCnt - 1 : 0;
              if (mCnt == 0) begin
                mRun = 0;
                mq = (modeSel == 3'd2 || modeSel == 3'd3);
              end
            end
          end
          3'd4: begin
            if (rise) begin mRun = 0; mq = 1; end
            else if (fall && mq) begin
              mCnt = bcd2bin(presetWord[11:0]); mTb = int'(presetWord[13:12]); mRun = 1;
            end else if (tk) begin
              mCnt = (mCnt > 0) ? mCnt - 1 : 0;
              if (mCnt == 0) begin mRun = 0; mq = 0; end
            end
          end
          default: begin mRun = 0; mq = 0; end
        endcase
      end
      mPrevS = startIn; mPrevR = releaseIn; cyc++;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [15:0] expBcd;
    expBcd = {2'b00, 2'(mTb), bin2bcd(mCnt)};
    tests++;
    if (outQ !== mq || int'(remainBin) != mCnt || remainBcd !== expBcd) begin
      fails++;
      $display("FAIL %s t=%0t actual q=%0b bin=%0d bcd=%h expected q=%0b bin=%0d bcd=%h",
               tag, $time, outQ, remainBin, remainBcd, mq, mCnt, expBcd);
    end
  endtask

  task automatic run(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      compareAll(tag);
    end
  endtask

  task automatic clearWith(input logic [2:0] m, input logic [15:0] p);
    clearIn = 1; run(2, "R8");
    modeSel = m; presetWord = p; startIn = 0; releaseIn = 0;
    run(2, "R8");
    clearIn = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "reset outQ", int'(outQ), 0);
    check("R8", "reset remainBin", int'(remainBin), 0);
    check("R8", "reset remainBcd", int'(remainBcd), 0);
    rstN = 1;

    // R3 pulse: early drop, then full elapse
    clearWith(3'd0, 16'h0005);
    startIn = 1; run(10, "R3"); startIn = 0; run(4, "R3");
    startIn = 1; run(30, "R3");
    check("R3", "pulse elapsed q", int'(outQ), 0);
    startIn = 0; run(3, "R3");

    // R4 extended pulse with retrigger
    clearWith(3'd1, 16'h0006);
    startIn = 1; run(2, "R4"); startIn = 0; run(10, "R4");
    startIn = 1; run(2, "R4"); startIn = 0; run(30, "R4");
    check("R4", "ext elapsed q", int'(outQ), 0);

    // R5 on-delay
    clearWith(3'd2, 16'h0004);
    startIn = 1; run(25, "R5");
    check("R5", "ondelay q after time", int'(outQ), 1);
    startIn = 0; run(2, "R5");
    check("R5", "ondelay q after drop", int'(outQ), 0);
    startIn = 1; run(6, "R5"); startIn = 0; run(20, "R5");

    // R6 latching on-delay
    clearWith(3'd3, 16'h0003);
    startIn = 1; run(2, "R6"); startIn = 0; run(5, "R6");
    startIn = 1; run(2, "R6"); startIn = 0; run(20, "R6");
    check("R6", "latch q set", int'(outQ), 1);
    startIn = 1; run(2, "R6"); startIn = 0; run(30, "R6");
    check("R6", "latch q held", int'(outQ), 1);
    clearIn = 1; run(2, "R8"); clearIn = 0; run(2, "R6");

    // R7 off-delay with halt by re-assert
    clearWith(3'd4, 16'h0004);
    startIn = 1; run(5, "R7"); startIn = 0; run(8, "R7");
    startIn = 1; run(10, "R7"); startIn = 0; run(12, "R7");
    check("R7", "off q still high", int'(outQ), 1);
    run(10, "R7");
    check("R7", "off q low after time", int'(outQ), 0);

    // R8 / R12: clear dominant; held start gives no edge
    clearWith(3'd0, 16'h0009);
    clearIn = 1; startIn = 1; run(5, "R8");
    check("R8", "clear blocks set", int'(outQ), 0);
    clearIn = 0; run(5, "R12");
    check("R12", "no edge no set", int'(outQ), 0);
    startIn = 0; run(2, "R12");

    // R9 release retrigger
    clearWith(3'd1, 16'h0005);
    startIn = 1; run(10, "R9"); releaseIn = 1; run(2, "R9"); releaseIn = 0; run(4, "R9");
    startIn = 0; run(2, "R9"); releaseIn = 1; run(2, "R9"); releaseIn = 0; run(30, "R9");
    clearWith(3'd4, 16'h0005);
    startIn = 1; run(3, "R9"); startIn = 0; run(3, "R9");
    releaseIn = 1; run(2, "R9"); releaseIn = 0; run(25, "R9");

    // R10 / R1 encodings
    clearWith(3'd1, 16'h1999);
    startIn = 1; run(1, "R10");
    check("R10", "bin of 999", int'(remainBin), 999);
    check("R10", "bcd word", int'(remainBcd), 16'h1999);
    clearWith(3'd1, 16'hC005);
    startIn = 1; run(1, "R1");
    check("R1", "high bits ignored", int'(remainBcd), 16'h0005);
    startIn = 0; run(30, "R1");

    // R11 idle codes
    clearWith(3'd5, 16'h0002);
    startIn = 1; run(15, "R11");
    check("R11", "idle q", int'(outQ), 0);
    startIn = 0;

    // R2 slower bases
    clearWith(3'd1, 16'h1002); startIn = 1; run(2, "R2"); startIn = 0; run(90, "R2");
    clearWith(3'd1, 16'h2001); startIn = 1; run(2, "R2"); startIn = 0; run(420, "R2");
    clearWith(3'd1, 16'h3001); startIn = 1; run(2, "R2"); startIn = 0; run(4100, "R2");
    check("R2", "10s base elapsed", int'(outQ), 0);

    // Random phase
    for (int seg = 0; seg < 24; seg++) begin
      logic [2:0] m;
      logic [15:0] p;
      m = 3'($urandom % 6);
      p = {2'($urandom % 4), 2'($urandom % 2), 4'($urandom % 2),
           4'($urandom % 10), 4'($urandom % 10)};
      clearWith(m, p);
      for (int c = 0; c < 500; c++) begin
        if ($urandom % 25 == 0) startIn = ~startIn;
        if ($urandom % 20 == 0) releaseIn = ~releaseIn;
        clearIn = ($urandom % 150 == 0);
        run(1, tagOf(m));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule